// File: doc/BRIEF.md
# Interrupt Destination and Inter-Processor Command Decoder

This block resolves where an interrupt message goes in a system of up to 32 local interrupt units. A sender writes a 64-bit command as two 32-bit halves: the upper half carries only the destination byte, and writing the lower half starts a send. The block combines the destination byte, the physical/logical mode bit and a two-bit shorthand with the per-unit addressing state (physical ID, logical destination byte and destination model). From these it forms a bitmask of target units.

The result leaves as a one-cycle pulse carrying the target mask, vector, delivery mode, trigger and level bits. Lowest-priority messages go to a single unit only: the lowest-numbered candidate. An INIT level-deassert message is consumed inside the block. It copies each target's physical ID into that target's arbitration ID and produces no pulse. The per-unit registers are reached through a small indexed register port.

Top module: `ipi_dest_decoder`

## Requirements
- R1: In physical mode (low-word bit 11 = 0), destination 0xFF targets every unit. Any other value targets only the lowest-numbered unit whose physical ID equals it, and no unit when none matches.
- R2: In logical mode (bit 11 = 1), a unit whose model is 0xF matches when the destination byte AND its logical byte is nonzero.
- R3: In logical mode, a unit whose model is 0x0 matches when both upper nibbles are equal and the lower nibbles share a set bit. A unit with any other model value never matches.
- R4: Shorthand (low-word bits [19:18]) behaves as follows: 0 uses the destination decode, 1 targets only the unit given by `self_unit`, 2 targets all units, and 3 targets all units except `self_unit`.
- R5: The low-word fields are vector [7:0], delivery mode [10:8], level bit 14 and trigger bit 15. The destination byte is bits [31:24] of the high word. A high-word write starts nothing.
- R6: A low-word write accepted at a clock edge raises `send_valid` for exactly one cycle after the following edge. The pulse carries the vector, the mode, the trigger and level bits, and the mask.
- R7: `busy` is high for the one cycle between acceptance and the pulse. A low-word write made while `busy` is high is dropped.
- R8: Delivery mode 1 (lowest priority) sends only the lowest-numbered set bit of the target mask.
- R9: Delivery mode 5 with level 0 and trigger 1 gives no pulse. Instead, every target's arbitration ID takes that target's physical ID.
- R10: Reserved mode 3 gives no pulse. Modes 0, 2, 4, 5 (other level/trigger combinations), 6 and 7 pulse with the full target mask and echo the mode.
- R11: Register select 0 reads and writes the ID byte in bits [31:24]. Select 1 does the same for the logical byte. Select 2 holds the model in bits [31:28], and its bits [27:0] read as all ones. Select 3 reads the arbitration ID in [31:24] and ignores writes. Reset values are ID = unit index, logical byte 0, model 0xF and arbitration ID 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Per-unit register write strobe |
| cfg_unit | input | UIDX_W | Unit index for register access |
| cfg_sel | input | 2 | Register select (0 ID, 1 logical, 2 model, 3 arbitration) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| self_unit | input | UIDX_W | Index of the sending unit, used by shorthands 1 and 3 |
| cmd_we_hi | input | 1 | Write strobe for the command high word |
| cmd_we_lo | input | 1 | Write strobe for the command low word (starts a send) |
| cmd_wdata | input | 32 | Command write data |
| busy | output | 1 | A send is being decoded; low-word writes are dropped |
| send_valid | output | 1 | One-cycle send pulse |
| send_mask | output | NUM_UNITS | Target bitmask |
| send_vector | output | 8 | Vector |
| send_mode | output | 3 | Delivery mode |
| send_trigger | output | 1 | Trigger bit |
| send_level | output | 1 | Level bit |

## Verification
The assertions assume that the inputs change only between clock edges and that `cfg_sel` always holds one of its four codes. The bench drives every input on the falling edge and uses only those codes. The assertions also assume that `self_unit` and the unit registers stay still while a send is being decoded. The bench holds them constant from the low-word write until the pulse has been sampled, and it changes configuration only between sends.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

   localparam int MAX_UNITS = 32;

   typedef enum logic [2:0] {
      DM_FIXED   = 3'd0,
      DM_LOWEST  = 3'd1,
      DM_SMI     = 3'd2,
      DM_RSVD    = 3'd3,
      DM_NMI     = 3'd4,
      DM_INIT    = 3'd5,
      DM_STARTUP = 3'd6,
      DM_EXTINT  = 3'd7
   } dlv_mode_e;

   typedef enum logic [1:0] {
      SH_NONE   = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } shorthand_e;

   typedef enum logic [1:0] {
      RS_ID      = 2'd0,
      RS_LOGICAL = 2'd1,
      RS_FORMAT  = 2'd2,
      RS_ARB     = 2'd3
   } reg_sel_e;

   localparam logic [3:0] MODEL_FLAT    = 4'hF;
   localparam logic [3:0] MODEL_CLUSTER = 4'h0;

   typedef struct packed {
      shorthand_e shorthand;
      logic       trigger;
      logic       level;
      logic       logical;
      dlv_mode_e  mode;
      logic [7:0] vector;
   } cmd_t;

   function automatic cmd_t unpack_cmd(logic [31:0] w);
      cmd_t c;
      c.vector    = w[7:0];
      c.mode      = dlv_mode_e'(w[10:8]);
      c.logical   = w[11];
      c.level     = w[14];
      c.trigger   = w[15];
      c.shorthand = shorthand_e'(w[19:18]);
      return c;
   endfunction

endpackage

// File: rtl/ipi_first_set.sv
module ipi_first_set #(
   parameter int W = 8
)(
   input  logic [W-1:0] vec,
   output logic [W-1:0] onehot
);
   // isolate lowest set bit by two's complement
   assign onehot = vec & (~vec + W'(1));
endmodule

// File: rtl/ipi_unit_regs.sv
module ipi_unit_regs import ipi_pkg::*; #(
   parameter int NUM_UNITS = 32,
   localparam int UIDX_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cfg_we,
   input  logic [UIDX_W-1:0]         cfg_unit,
   input  logic [1:0]                cfg_sel,
   input  logic [7:0]                wr_byte,
   input  logic [NUM_UNITS-1:0]      arb_load,
   output logic [NUM_UNITS-1:0][7:0] phys_id,
   output logic [NUM_UNITS-1:0][7:0] log_dest,
   output logic [NUM_UNITS-1:0][3:0] model,
   output logic [31:0]               cfg_rdata
);
   logic [NUM_UNITS-1:0][7:0] arb_id;

   for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
      logic hit;
      assign hit = cfg_we && (int'(cfg_unit) == g);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            phys_id[g]  <= 8'(g);
            log_dest[g] <= 8'h00;
            model[g]    <= MODEL_FLAT;
         end else if (hit) begin
            case (reg_sel_e'(cfg_sel))
               RS_ID:      phys_id[g]  <= wr_byte;
               RS_LOGICAL: log_dest[g] <= wr_byte;
               RS_FORMAT:  model[g]    <= wr_byte[7:4];
               default:    ;
            endcase
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            arb_id[g] <= 8'h00;
         else if (arb_load[g])
            arb_id[g] <= phys_id[g];
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (int'(cfg_unit) < NUM_UNITS) begin
         case (reg_sel_e'(cfg_sel))
            RS_ID:      cfg_rdata = {phys_id[cfg_unit], 24'h0};
            RS_LOGICAL: cfg_rdata = {log_dest[cfg_unit], 24'h0};
            RS_FORMAT:  cfg_rdata = {model[cfg_unit], 28'hFFF_FFFF};
            RS_ARB:     cfg_rdata = {arb_id[cfg_unit], 24'h0};
            default:    cfg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/ipi_dest_match.sv
module ipi_dest_match import ipi_pkg::*; #(
   parameter int NUM_UNITS       = 32,
   parameter bit PHYS_FIRST_ONLY = 1'b1
)(
   input  logic [7:0]                dest,
   input  logic                      logical,
   input  logic [NUM_UNITS-1:0][7:0] phys_id,
   input  logic [NUM_UNITS-1:0][7:0] log_dest,
   input  logic [NUM_UNITS-1:0][3:0] model,
   output logic [NUM_UNITS-1:0]      mask
);
   logic [NUM_UNITS-1:0] phys_hit;
   logic [NUM_UNITS-1:0] phys_sel;
   logic [NUM_UNITS-1:0] log_hit;

   for (genvar g = 0; g < NUM_UNITS; g++) begin : g_cmp
      logic flat_hit, clus_hit;
      assign phys_hit[g] = (phys_id[g] == dest);
      assign flat_hit    = |(dest & log_dest[g]);
      assign clus_hit    = (dest[7:4] == log_dest[g][7:4]) &&
                           (|(dest[3:0] & log_dest[g][3:0]));
      assign log_hit[g]  = (model[g] == MODEL_FLAT)    ? flat_hit :
                           (model[g] == MODEL_CLUSTER) ? clus_hit : 1'b0;
   end

   if (PHYS_FIRST_ONLY) begin : g_phys_first
      ipi_first_set #(.W(NUM_UNITS)) u_first (
         .vec    (phys_hit),
         .onehot (phys_sel)
      );
   end else begin : g_phys_all
      assign phys_sel = phys_hit;
   end

   always_comb begin
      if (logical)
         mask = log_hit;
      else if (dest == 8'hFF)
         mask = '1;
      else
         mask = phys_sel;
   end
endmodule

// File: rtl/ipi_dest_decoder.sv
module ipi_dest_decoder import ipi_pkg::*; #(
   parameter int NUM_UNITS       = 32,
   parameter bit PHYS_FIRST_ONLY = 1'b1,
   localparam int UIDX_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [UIDX_W-1:0]    cfg_unit,
   input  logic [1:0]           cfg_sel,
   input  logic [31:0]          cfg_wdata,
   output logic [31:0]          cfg_rdata,
   input  logic [UIDX_W-1:0]    self_unit,
   input  logic                 cmd_we_hi,
   input  logic                 cmd_we_lo,
   input  logic [31:0]          cmd_wdata,
   output logic                 busy,
   output logic                 send_valid,
   output logic [NUM_UNITS-1:0] send_mask,
   output logic [7:0]           send_vector,
   output logic [2:0]           send_mode,
   output logic                 send_trigger,
   output logic                 send_level
);
   if (NUM_UNITS < 1 || NUM_UNITS > MAX_UNITS) begin : g_bad_units
      $error("NUM_UNITS out of range");
   end

   logic                      unused_bits;
   logic [NUM_UNITS-1:0][7:0] phys_id;
   logic [NUM_UNITS-1:0][7:0] log_dest;
   logic [NUM_UNITS-1:0][3:0] model;
   logic [NUM_UNITS-1:0]      arb_load;
   logic [NUM_UNITS-1:0]      dest_mask;
   logic [NUM_UNITS-1:0]      tgt_mask;
   logic [NUM_UNITS-1:0]      low_mask;
   logic [NUM_UNITS-1:0]      self_hot;
   logic [NUM_UNITS-1:0]      out_mask;
   logic [7:0]                dest_q;
   cmd_t                      cmd_q;
   logic                      pending;
   logic                      init_deassert;
   logic                      fire;

   assign unused_bits = ^{cmd_wdata[23:20], cmd_wdata[17:16],
                          cmd_wdata[13:12], cfg_wdata[23:0]};

   ipi_unit_regs #(.NUM_UNITS(NUM_UNITS)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_unit  (cfg_unit),
      .cfg_sel   (cfg_sel),
      .wr_byte   (cfg_wdata[31:24]),
      .arb_load  (arb_load),
      .phys_id   (phys_id),
      .log_dest  (log_dest),
      .model     (model),
      .cfg_rdata (cfg_rdata)
   );

   // command halves; the low half launches a decode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dest_q  <= 8'h00;
         cmd_q   <= '0;
         pending <= 1'b0;
      end else begin
         if (cmd_we_hi)
            dest_q <= cmd_wdata[31:24];
         if (cmd_we_lo && !pending) begin
            cmd_q   <= unpack_cmd(cmd_wdata);
            pending <= 1'b1;
         end else begin
            pending <= 1'b0;
         end
      end
   end

   assign busy = pending;

   ipi_dest_match #(
      .NUM_UNITS       (NUM_UNITS),
      .PHYS_FIRST_ONLY (PHYS_FIRST_ONLY)
   ) u_match (
      .dest     (dest_q),
      .logical  (cmd_q.logical),
      .phys_id  (phys_id),
      .log_dest (log_dest),
      .model    (model),
      .mask     (dest_mask)
   );

   assign self_hot = (int'(self_unit) < NUM_UNITS) ?
                     (NUM_UNITS'(1) << self_unit) : '0;

   always_comb begin
      case (cmd_q.shorthand)
         SH_NONE:   tgt_mask = dest_mask;
         SH_SELF:   tgt_mask = self_hot;
         SH_ALL:    tgt_mask = '1;
         SH_OTHERS: tgt_mask = ~self_hot;
         default:   tgt_mask = '0;
      endcase
   end

   ipi_first_set #(.W(NUM_UNITS)) u_lowest (
      .vec    (tgt_mask),
      .onehot (low_mask)
   );

   assign out_mask      = (cmd_q.mode == DM_LOWEST) ? low_mask : tgt_mask;
   assign init_deassert = (cmd_q.mode == DM_INIT) && !cmd_q.level && cmd_q.trigger;
   assign fire          = pending && !init_deassert && (cmd_q.mode != DM_RSVD);
   assign arb_load      = (pending && init_deassert) ? tgt_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         send_valid   <= 1'b0;
         send_mask    <= '0;
         send_vector  <= 8'h00;
         send_mode    <= 3'd0;
         send_trigger <= 1'b0;
         send_level   <= 1'b0;
      end else begin
         send_valid <= fire;
         if (fire) begin
            send_mask    <= out_mask;
            send_vector  <= cmd_q.vector;
            send_mode    <= cmd_q.mode;
            send_trigger <= cmd_q.trigger;
            send_level   <= cmd_q.level;
         end
      end
   end
endmodule

// File: rtl/ipi_dest_decoder_chk.sv
module ipi_dest_decoder_chk import ipi_pkg::*; #(
   parameter int NUM_UNITS = 32
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           cfg_sel,
   input logic [31:0]          cfg_rdata,
   input logic                 cmd_we_lo,
   input logic                 busy,
   input logic                 send_valid,
   input logic [NUM_UNITS-1:0] send_mask,
   input logic [2:0]           send_mode,
   input logic                 send_trigger,
   input logic                 send_level,
   input cmd_t                 cmd_q
);
   assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      send_valid |=> !send_valid);

   assert_pulse_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      send_valid |-> $past(busy));

   assert_busy_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   assert_busy_drops_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_we_lo) |=> $stable(cmd_q));

   assert_lowest_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (send_valid && send_mode == 3'd1) |-> $onehot0(send_mask));

   assert_no_init_deassert_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (send_valid && send_mode == 3'd5) |-> !(send_trigger && !send_level));

   assert_no_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
      send_valid |-> (send_mode != 3'd3));

   assert_format_ones_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sel == 2'd2) |-> (&cfg_rdata[27:0]));
endmodule

bind ipi_dest_decoder ipi_dest_decoder_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_sel      (cfg_sel),
   .cfg_rdata    (cfg_rdata),
   .cmd_we_lo    (cmd_we_lo),
   .busy         (busy),
   .send_valid   (send_valid),
   .send_mask    (send_mask),
   .send_mode    (send_mode),
   .send_trigger (send_trigger),
   .send_level   (send_level),
   .cmd_q        (cmd_q)
);

// File: tb/test_ipi_dest_decoder.sv
module test_ipi_dest_decoder;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_unit = '0;
   logic [1:0]    cfg_sel = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic [2:0]    self_unit = '0;
   logic          cmd_we_hi = 1'b0;
   logic          cmd_we_lo = 1'b0;
   logic [31:0]   cmd_wdata = '0;
   logic          busy;
   logic          send_valid;
   logic [N-1:0]  send_mask;
   logic [7:0]    send_vector;
   logic [2:0]    send_mode;
   logic          send_trigger;
   logic          send_level;

   int n_checks = 0;
   int n_err    = 0;

   logic [7:0] b_id    [N];
   logic [7:0] b_ldr   [N];
   logic [3:0] b_model [N];

   always #(CLK_PERIOD/2) clk = ~clk;

   ipi_dest_decoder #(.NUM_UNITS(N)) i_ipi_dest_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_unit(cfg_unit),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .self_unit(self_unit), .cmd_we_hi(cmd_we_hi), .cmd_we_lo(cmd_we_lo),
      .cmd_wdata(cmd_wdata), .busy(busy), .send_valid(send_valid),
      .send_mask(send_mask), .send_vector(send_vector), .send_mode(send_mode),
      .send_trigger(send_trigger), .send_level(send_level)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_lo(logic [7:0] vec, logic [2:0] mode,
                                         logic lg, logic lvl, logic trig,
                                         logic [1:0] sh);
      return {12'h0, sh, 2'b00, trig, lvl, 2'b00, lg, mode, vec};
   endfunction

   function automatic logic [7:0] exp_dest(logic [7:0] d, logic lg);
      logic [7:0] m = 8'h00;
      if (!lg) begin
         if (d == 8'hFF) return 8'hFF;
         for (int i = 0; i < N; i++) if (b_id[i] == d) return 8'(1 << i);
         return 8'h00;
      end
      for (int i = 0; i < N; i++) begin
         if (b_model[i] == 4'hF)
            m[i] = |(d & b_ldr[i]);
         else if (b_model[i] == 4'h0)
            m[i] = (d[7:4] == b_ldr[i][7:4]) && (|(d[3:0] & b_ldr[i][3:0]));
      end
      return m;
   endfunction

   function automatic logic [7:0] lowest_of(logic [7:0] m);
      for (int i = 0; i < N; i++) if (m[i]) return 8'(1 << i);
      return 8'h00;
   endfunction

   task automatic cfg_wr(int u, int sel, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_unit = 3'(u); cfg_sel = 2'(sel); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cfg_chk(string req, int u, int sel, logic [31:0] exp);
      @(negedge clk);
      cfg_unit = 3'(u); cfg_sel = 2'(sel);
      #1;
      check(req, cfg_rdata, exp);
      cfg_sel = 2'd0;
   endtask

   // writes high then low word; returns after the pulse cycle is reachable
   task automatic issue(logic [7:0] dest, logic [31:0] lo);
      @(negedge clk);
      cmd_we_hi = 1'b1; cmd_wdata = {dest, 24'h0};
      @(negedge clk);
      cmd_we_hi = 1'b0; cmd_we_lo = 1'b1; cmd_wdata = lo;
      @(negedge clk);
      cmd_we_lo = 1'b0;
      check("R7 busy after accept", 32'(busy), 32'd1);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         b_id[i] = 8'(i); b_ldr[i] = 8'h00; b_model[i] = 4'hF;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check("R6 valid at reset", 32'(send_valid), 32'd0);
      check("R7 busy at reset", 32'(busy), 32'd0);
      for (int u = 0; u < N; u++) begin
         cfg_chk("R11 reset id", u, 0, {8'(u), 24'h0});
         cfg_chk("R11 reset logical", u, 1, 32'h0);
         cfg_chk("R11 reset format", u, 2, 32'hFFFF_FFFF);
         cfg_chk("R11 reset arb", u, 3, 32'h0);
      end

      // physical IDs, with unit 6 duplicating unit 2
      for (int u = 0; u < N; u++) begin
         b_id[u] = (u == 6) ? 8'd7 : 8'(u * 3 + 1);
         cfg_wr(u, 0, {b_id[u], 24'h00_1234});
         cfg_chk("R11 id readback", u, 0, {b_id[u], 24'h0});
      end
      cfg_wr(2, 3, 32'hAB00_0000);
      cfg_chk("R11 arb write ignored", 2, 3, 32'h0);

      // R1 physical sweep
      for (int d = 0; d < 256; d++) begin
         issue(8'(d), mk_lo(8'(d) ^ 8'h5A, 3'd0, 1'b0, 1'b1, d[0], 2'd0));
         check("R1 physical mask", 32'(send_mask), 32'(exp_dest(8'(d), 1'b0)));
         check("R6 valid", 32'(send_valid), 32'd1);
         check("R5 vector field", 32'(send_vector), 32'(8'(d) ^ 8'h5A));
         check("R5 trigger field", 32'(send_trigger), 32'(d[0]));
      end

      // R2 flat logical sweep, also lowest priority R8
      for (int u = 0; u < N; u++) begin
         b_ldr[u] = 8'(1 << u);
         cfg_wr(u, 1, {b_ldr[u], 24'h0});
      end
      for (int d = 0; d < 256; d++) begin
         issue(8'h00, mk_lo(8'h40, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0));
         check("R2 flat before dest", 32'(send_mask), 32'(exp_dest(8'h00, 1'b1)));
         issue(8'(d), mk_lo(8'h41, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0));
         check("R2 flat mask", 32'(send_mask), 32'(exp_dest(8'(d), 1'b1)));
         issue(8'(d), mk_lo(8'h42, 3'd1, 1'b1, 1'b0, 1'b0, 2'd0));
         check("R8 lowest mask", 32'(send_mask), 32'(lowest_of(exp_dest(8'(d), 1'b1))));
         check("R8 lowest mode", 32'(send_mode), 32'd1);
      end

      // R3 cluster logical sweep, unit 7 with an unsupported model
      for (int u = 0; u < N; u++) begin
         b_ldr[u]   = 8'((((u / 4) + 1) << 4) | (1 << (u % 4)));
         b_model[u] = (u == 7) ? 4'h5 : 4'h0;
         cfg_wr(u, 1, {b_ldr[u], 24'h0});
         cfg_wr(u, 2, {b_model[u], 28'h0});
         cfg_chk("R11 format readback", u, 2, {b_model[u], 28'hFFF_FFFF});
         cfg_chk("R11 logical readback", u, 1, {b_ldr[u], 24'h0});
      end
      for (int d = 0; d < 256; d++) begin
         issue(8'(d), mk_lo(8'h50, 3'd0, 1'b1, 1'b0, 1'b0, 2'd0));
         check("R3 cluster mask", 32'(send_mask), 32'(exp_dest(8'(d), 1'b1)));
      end

      // R4 shorthands for every self index
      for (int s = 0; s < N; s++) begin
         self_unit = 3'(s);
         for (int sh = 1; sh < 4; sh++) begin
            logic [7:0] e;
            e = (sh == 1) ? 8'(1 << s) : (sh == 2) ? 8'hFF : ~8'(1 << s);
            issue(8'h00, mk_lo(8'h60, 3'd4, 1'b0, 1'b0, 1'b0, 2'(sh)));
            check("R4 shorthand mask", 32'(send_mask), 32'(e));
         end
      end
      self_unit = 3'd0;

      // R10 delivering modes echo and full mask; pulse is single (R6)
      for (int m = 0; m < 8; m++) begin
         if (m == 1 || m == 3) continue;
         issue(8'h00, mk_lo(8'(m), 3'(m), 1'b0, 1'b1, 1'b1, 2'd2));
         check("R10 mode echo", 32'(send_mode), 32'(m));
         check("R10 full mask", 32'(send_mask), 32'hFF);
         check("R5 level field", 32'(send_level), 32'd1);
         @(negedge clk);
         check("R6 single pulse", 32'(send_valid), 32'd0);
      end
      issue(8'h00, mk_lo(8'h33, 3'd3, 1'b0, 1'b0, 1'b0, 2'd2));
      check("R10 reserved no pulse", 32'(send_valid), 32'd0);
      @(negedge clk);
      check("R10 reserved no pulse later", 32'(send_valid), 32'd0);

      // R9 INIT level-deassert
      issue(8'd10, mk_lo(8'h00, 3'd5, 1'b0, 1'b0, 1'b1, 2'd0));
      check("R9 no pulse", 32'(send_valid), 32'd0);
      cfg_chk("R9 arb target", 3, 3, {8'd10, 24'h0});
      cfg_chk("R9 arb non-target", 0, 3, 32'h0);
      issue(8'h00, mk_lo(8'h00, 3'd5, 1'b0, 1'b0, 1'b1, 2'd3));
      check("R9 no pulse others", 32'(send_valid), 32'd0);
      for (int u = 0; u < N; u++)
         cfg_chk("R9 arb after others", u, 3, (u == 0) ? 32'h0 : {b_id[u], 24'h0});

      // R7 write while busy is dropped
      @(negedge clk);
      cmd_we_lo = 1'b1; cmd_wdata = mk_lo(8'h11, 3'd0, 1'b0, 1'b0, 1'b0, 2'd2);
      @(negedge clk);
      check("R7 busy", 32'(busy), 32'd1);
      cmd_wdata = mk_lo(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 2'd2);
      @(negedge clk);
      cmd_we_lo = 1'b0;
      check("R7 first send", 32'(send_valid), 32'd1);
      check("R7 first vector", 32'(send_vector), 32'h11);
      @(negedge clk);
      check("R7 dropped no pulse", 32'(send_valid), 32'd0);
      @(negedge clk);
      check("R7 dropped no pulse later", 32'(send_valid), 32'd0);

      // R5 high word alone starts nothing
      @(negedge clk);
      cmd_we_hi = 1'b1; cmd_wdata = 32'hFF00_0000;
      @(negedge clk);
      cmd_we_hi = 1'b0;
      for (int k = 0; k < 3; k++) begin
         check("R5 high write no busy", 32'(busy), 32'd0);
         check("R5 high write no pulse", 32'(send_valid), 32'd0);
         @(negedge clk);
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule